// File: doc/BRIEF.md
# Interrupt Source State Controller

This block keeps the routing and delivery state for a bank of interrupt sources whose external numbers start at a fixed base. Each source is built as either a level source or a message (edge) source. For each source the block stores a target server, an active priority, a parked priority and four status flags: asserted, sent, rejected and held-while-masked. A priority of 0xFF means the source is masked.

Input lines, configuration commands and notifications from a single presentation unit (reject, end-of-interrupt, resend) change that state. Whenever a source must be delivered, the block sets an internal request bit. An output stage then presents the lowest-numbered requesting source as an offer of (source number, priority, server) on a valid/ready stream. While `offer_ready` is low the offer stays on the port unchanged, and further requests wait inside their slots. A resend request starts a scan that visits one source per clock.

Top module: `isc_source_ctrl`

## Requirements
- R1: After reset every source has priority 0xFF and parked priority 0xFF, all flags are clear, and `offer_valid` is low. A masked source is never offered.
- R2: A level source records its line as its asserted flag on every line change. It is then offered, and its sent flag set, only when its priority is not 0xFF, it is asserted and it is not already sent.
- R3: On a rising line, an unmasked message source is offered once. A falling line on a message source has no effect.
- R4: A rising line on a masked message source sets its held flag and produces no offer.
- R5: A reject for a source sets its rejected flag and clears its sent flag.
- R6: A one-cycle `resend_req` scans every source in turn. A message source with the rejected flag set has the flag cleared and is re-offered if unmasked. A level source applies the rule of R2.
- R7: `cfg_op`=0 (route) stores the server and priority, and copies the priority into the parked priority. After any accepted command, a message source that is held and now unmasked clears its held flag and is offered. A level source applies the rule of R2.
- R8: End-of-interrupt clears the sent flag of a level source and leaves a message source unchanged.
- R9: `cfg_op`=1 (disable) copies the priority into the parked priority and sets the priority to 0xFF. `cfg_op`=2 (enable) copies the parked priority back into the priority.
- R10: A command is refused, with `cfg_ack` and `cfg_err` high one cycle after `cfg_valid` and no state change, in any of these cases: the source number lies outside [BASE, BASE+N), the op is 3, or a route command names a server at or above NUM_SERVERS or a priority above 0xFF. An accepted command gives `cfg_ack` high and `cfg_err` low.
- R11: While `offer_valid` is high and `offer_ready` is low, the offer fields stay stable. When several sources request at once, the lowest source number is offered first.
- R12: A source rejected in a cycle is not loaded as the new offer in that same cycle. A reject that arrives with a resend request takes effect before the scan visits any source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_i | input | N | Interrupt input line of each source |
| cfg_valid | input | 1 | Configuration command strobe |
| cfg_op | input | 2 | 0 route, 1 disable, 2 enable, 3 refused |
| cfg_num | input | NUM_W | Source number of the command |
| cfg_server | input | SRV_W | Target server (route) |
| cfg_prio | input | 9 | Priority (route); values above 0xFF are refused |
| cfg_ack | output | 1 | Command completed, one cycle after strobe |
| cfg_err | output | 1 | Command refused, valid with cfg_ack |
| rej_valid | input | 1 | Reject notification strobe |
| rej_num | input | NUM_W | Rejected source number |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_num | input | NUM_W | Source number being completed |
| resend_req | input | 1 | Start a resend scan |
| offer_valid | output | 1 | Offer stream valid |
| offer_ready | input | 1 | Offer stream ready |
| offer_num | output | NUM_W | Offered source number |
| offer_prio | output | 8 | Offered priority |
| offer_server | output | SRV_W | Offered target server |

## Verification
On every cycle the assertions check the offer stream: fields stay stable under back-pressure, no offer carries the masked priority, offered numbers stay within range, and a just-rejected source is never loaded as the next offer. They also check that every command strobe is answered with an acknowledge. Only the directed scenarios can show the per-source flag behaviour, because that state is visible only through later offers: level re-offer after reject or end-of-interrupt, held message release on enable, refused commands leaving state untouched, and lowest-number ordering.

// File: rtl/isc_pkg.sv
package isc_pkg;
  localparam logic [7:0] PRIO_OFF = 8'hFF;

  typedef enum logic [1:0] {
    CFG_ROUTE  = 2'd0,
    CFG_PARK   = 2'd1,
    CFG_UNPARK = 2'd2,
    CFG_BAD    = 2'd3
  } cfg_op_e;

  typedef struct packed {
    logic asserted;
    logic sent;
    logic rejected;
    logic held;
  } src_flags_t;
endpackage

// File: rtl/isc_src_slot.sv
module isc_src_slot
  import isc_pkg::*;
#(
  parameter int  SRV_W    = 3,
  parameter bit  IS_LEVEL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_i,
  input  logic             cfg_hit,
  input  logic [1:0]       cfg_op,
  input  logic [SRV_W-1:0] cfg_server,
  input  logic [7:0]       cfg_prio,
  input  logic             rej_hit,
  input  logic             eoi_hit,
  input  logic             scan_hit,
  input  logic             take_i,
  output logic             want_o,
  output logic [7:0]       prio_o,
  output logic [SRV_W-1:0] server_o
);
  src_flags_t       flags_q, flags_d;
  logic [7:0]       prio_q, prio_d, park_q, park_d;
  logic [SRV_W-1:0] srv_q, srv_d;
  logic             want_q, want_d;
  logic             line_q;
  logic             level_try;

  always_comb begin
    flags_d   = flags_q;
    prio_d    = prio_q;
    park_d    = park_q;
    srv_d     = srv_q;
    want_d    = want_q & ~take_i;
    level_try = 1'b0;

    // notifications first: reject then completion
    if (rej_hit) begin
      flags_d.rejected = 1'b1;
      flags_d.sent     = 1'b0;
    end
    if (eoi_hit && IS_LEVEL) begin
      flags_d.sent = 1'b0;
    end

    // input line
    if (IS_LEVEL) begin
      if (line_i != line_q) begin
        flags_d.asserted = line_i;
        level_try        = 1'b1;
      end
    end else if (line_i && !line_q) begin
      if (prio_q == PRIO_OFF) flags_d.held = 1'b1;
      else                    want_d       = 1'b1;
    end

    // configuration
    if (cfg_hit) begin
      case (cfg_op)
        CFG_ROUTE: begin
          srv_d  = cfg_server;
          prio_d = cfg_prio;
          park_d = cfg_prio;
        end
        CFG_PARK: begin
          park_d = prio_q;
          prio_d = PRIO_OFF;
        end
        CFG_UNPARK: begin
          prio_d = park_q;
        end
        default: ;
      endcase
      if (IS_LEVEL) begin
        level_try = 1'b1;
      end else if (flags_d.held && prio_d != PRIO_OFF) begin
        flags_d.held = 1'b0;
        want_d       = 1'b1;
      end
    end

    // resend scan visit
    if (scan_hit) begin
      if (IS_LEVEL) begin
        level_try = 1'b1;
      end else if (flags_d.rejected) begin
        flags_d.rejected = 1'b0;
        if (prio_d != PRIO_OFF) want_d = 1'b1;
      end
    end

    if (IS_LEVEL && level_try && prio_d != PRIO_OFF &&
        flags_d.asserted && !flags_d.sent) begin
      flags_d.sent = 1'b1;
      want_d       = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      prio_q  <= PRIO_OFF;
      park_q  <= PRIO_OFF;
      srv_q   <= '0;
      want_q  <= 1'b0;
      line_q  <= 1'b0;
    end else begin
      flags_q <= flags_d;
      prio_q  <= prio_d;
      park_q  <= park_d;
      srv_q   <= srv_d;
      want_q  <= want_d;
      line_q  <= line_i;
    end
  end

  assign want_o   = want_q;
  assign prio_o   = prio_q;
  assign server_o = srv_q;
endmodule

// File: rtl/isc_scan_ctrl.sv
module isc_scan_ctrl #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  output logic [N-1:0] visit_o
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  logic             active_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      idx_q    <= '0;
    end else if (active_q) begin
      if (idx_q == LAST) active_q <= 1'b0;
      else               idx_q    <= idx_q + 1'b1;
    end
  end

  always_comb begin
    visit_o = '0;
    for (int i = 0; i < N; i++) begin
      if (active_q && idx_q == IDX_W'(i)) visit_o[i] = 1'b1;
    end
  end
endmodule

// File: rtl/isc_offer_arb.sv
module isc_offer_arb
  import isc_pkg::*;
#(
  parameter int N     = 8,
  parameter int NUM_W = 8,
  parameter int SRV_W = 3,
  parameter int BASE  = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N-1:0]              want_i,
  input  logic [N-1:0]              block_i,
  input  logic [N-1:0][7:0]         prio_i,
  input  logic [N-1:0][SRV_W-1:0]   server_i,
  input  logic                      ready_i,
  output logic [N-1:0]              take_o,
  output logic                      valid_o,
  output logic [NUM_W-1:0]          num_o,
  output logic [7:0]                prio_o,
  output logic [SRV_W-1:0]          server_o
);
  localparam logic [NUM_W-1:0] BASE_V = NUM_W'(BASE);

  logic [N-1:0]     elig;
  logic             found;
  logic [NUM_W-1:0] pick_num;
  logic [7:0]       pick_prio;
  logic [SRV_W-1:0] pick_srv;
  logic             load;

  logic             valid_q;
  logic [NUM_W-1:0] num_q;
  logic [7:0]       prio_q;
  logic [SRV_W-1:0] srv_q;

  assign load = !valid_q || ready_i;

  for (genvar g = 0; g < N; g++) begin : g_elig
    assign elig[g] = want_i[g] && !block_i[g] && (prio_i[g] != PRIO_OFF);
  end

  always_comb begin
    found     = 1'b0;
    pick_num  = '0;
    pick_prio = PRIO_OFF;
    pick_srv  = '0;
    take_o    = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i]) begin
        found     = 1'b1;
        pick_num  = BASE_V + NUM_W'(i);
        pick_prio = prio_i[i];
        pick_srv  = server_i[i];
        take_o    = '0;
        take_o[i] = load;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      num_q   <= '0;
      prio_q  <= PRIO_OFF;
      srv_q   <= '0;
    end else if (load) begin
      valid_q <= found;
      num_q   <= pick_num;
      prio_q  <= pick_prio;
      srv_q   <= pick_srv;
    end
  end

  assign valid_o  = valid_q;
  assign num_o    = num_q;
  assign prio_o   = prio_q;
  assign server_o = srv_q;
endmodule

// File: rtl/isc_source_ctrl.sv
module isc_source_ctrl
  import isc_pkg::*;
#(
  parameter int           N           = 8,
  parameter int           BASE        = 16,
  parameter int           NUM_W       = 8,
  parameter int           NUM_SERVERS = 5,
  parameter int           SRV_W       = 3,
  parameter logic [N-1:0] LEVEL_MASK  = 8'hF0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     line_i,
  input  logic             cfg_valid,
  input  logic [1:0]       cfg_op,
  input  logic [NUM_W-1:0] cfg_num,
  input  logic [SRV_W-1:0] cfg_server,
  input  logic [8:0]       cfg_prio,
  output logic             cfg_ack,
  output logic             cfg_err,
  input  logic             rej_valid,
  input  logic [NUM_W-1:0] rej_num,
  input  logic             eoi_valid,
  input  logic [NUM_W-1:0] eoi_num,
  input  logic             resend_req,
  output logic             offer_valid,
  input  logic             offer_ready,
  output logic [NUM_W-1:0] offer_num,
  output logic [7:0]       offer_prio,
  output logic [SRV_W-1:0] offer_server
);
  localparam logic [NUM_W:0]   LO_V   = (NUM_W+1)'(BASE);
  localparam logic [NUM_W:0]   HI_V   = (NUM_W+1)'(BASE + N);
  localparam logic [NUM_W-1:0] BASE_V = NUM_W'(BASE);
  localparam logic [SRV_W:0]   SRV_LIM = (SRV_W+1)'(NUM_SERVERS);

  function automatic logic in_range(input logic [NUM_W-1:0] num);
    return ({1'b0, num} >= LO_V) && ({1'b0, num} < HI_V);
  endfunction

  logic [NUM_W-1:0] cfg_idx, rej_idx, eoi_idx;
  logic             cfg_ok;
  cfg_op_e          op;

  assign cfg_idx = cfg_num - BASE_V;
  assign rej_idx = rej_num - BASE_V;
  assign eoi_idx = eoi_num - BASE_V;
  assign op      = cfg_op_e'(cfg_op);

  always_comb begin
    cfg_ok = in_range(cfg_num) && (op != CFG_BAD);
    if (op == CFG_ROUTE) begin
      if ({1'b0, cfg_server} >= SRV_LIM) cfg_ok = 1'b0;
      if (cfg_prio[8])                   cfg_ok = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_ack <= 1'b0;
      cfg_err <= 1'b0;
    end else begin
      cfg_ack <= cfg_valid;
      cfg_err <= cfg_valid && !cfg_ok;
    end
  end

  logic [N-1:0]            cfg_hit, rej_hit, eoi_hit, scan_hit, take, want;
  logic [N-1:0][7:0]       prio;
  logic [N-1:0][SRV_W-1:0] server;

  for (genvar g = 0; g < N; g++) begin : g_dec
    assign cfg_hit[g] = cfg_valid && cfg_ok && (cfg_idx == NUM_W'(g));
    assign rej_hit[g] = rej_valid && in_range(rej_num) && (rej_idx == NUM_W'(g));
    assign eoi_hit[g] = eoi_valid && in_range(eoi_num) && (eoi_idx == NUM_W'(g));
  end

  isc_scan_ctrl #(.N(N)) u_scan (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (resend_req),
    .visit_o (scan_hit)
  );

  for (genvar g = 0; g < N; g++) begin : g_slot
    isc_src_slot #(.SRV_W(SRV_W), .IS_LEVEL(LEVEL_MASK[g])) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_i     (line_i[g]),
      .cfg_hit    (cfg_hit[g]),
      .cfg_op     (cfg_op),
      .cfg_server (cfg_server),
      .cfg_prio   (cfg_prio[7:0]),
      .rej_hit    (rej_hit[g]),
      .eoi_hit    (eoi_hit[g]),
      .scan_hit   (scan_hit[g]),
      .take_i     (take[g]),
      .want_o     (want[g]),
      .prio_o     (prio[g]),
      .server_o   (server[g])
    );
  end

  isc_offer_arb #(.N(N), .NUM_W(NUM_W), .SRV_W(SRV_W), .BASE(BASE)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .want_i   (want),
    .block_i  (rej_hit),
    .prio_i   (prio),
    .server_i (server),
    .ready_i  (offer_ready),
    .take_o   (take),
    .valid_o  (offer_valid),
    .num_o    (offer_num),
    .prio_o   (offer_prio),
    .server_o (offer_server)
  );
endmodule

// File: rtl/isc_source_ctrl_chk.sv
module isc_source_ctrl_chk #(
  parameter int N     = 8,
  parameter int BASE  = 16,
  parameter int NUM_W = 8,
  parameter int SRV_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_valid,
  input logic             cfg_ack,
  input logic             cfg_err,
  input logic             rej_valid,
  input logic [NUM_W-1:0] rej_num,
  input logic             offer_valid,
  input logic             offer_ready,
  input logic [NUM_W-1:0] offer_num,
  input logic [7:0]       offer_prio,
  input logic [SRV_W-1:0] offer_server
);
  localparam logic [NUM_W:0] LO_V = (NUM_W+1)'(BASE);
  localparam logic [NUM_W:0] HI_V = (NUM_W+1)'(BASE + N);

  // R11: offer held stable under back-pressure
  a_r11_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (offer_valid && !offer_ready) |=> (offer_valid && $stable(offer_num) &&
                                       $stable(offer_prio) && $stable(offer_server)));

  // R1: masked priority is never offered
  a_r1_no_masked_offer: assert property (@(posedge clk) disable iff (!rst_n)
    offer_valid |-> (offer_prio != 8'hFF));

  // R11: offered number within the source range
  a_r11_num_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    offer_valid |-> (({1'b0, offer_num} >= LO_V) && ({1'b0, offer_num} < HI_V)));

  // R12: a source rejected this cycle is not the next loaded offer
  a_r12_no_offer_on_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (rej_valid && (!offer_valid || offer_ready)) |=>
      !(offer_valid && offer_num == $past(rej_num)));

  // R10: every command is acknowledged next cycle
  a_r10_cmd_acked: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |=> cfg_ack);

  // R10: an error only comes with an acknowledge
  a_r10_err_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> cfg_ack);
endmodule

bind isc_source_ctrl isc_source_ctrl_chk #(
  .N(N), .BASE(BASE), .NUM_W(NUM_W), .SRV_W(SRV_W)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_valid    (cfg_valid),
  .cfg_ack      (cfg_ack),
  .cfg_err      (cfg_err),
  .rej_valid    (rej_valid),
  .rej_num      (rej_num),
  .offer_valid  (offer_valid),
  .offer_ready  (offer_ready),
  .offer_num    (offer_num),
  .offer_prio   (offer_prio),
  .offer_server (offer_server)
);

// File: tb/isc_source_ctrl_tb_top.sv
module isc_source_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int NUM_W = 8;
  localparam int SRV_W = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [N-1:0]     line_i = '0;
  logic             cfg_valid = 1'b0;
  logic [1:0]       cfg_op = 2'd0;
  logic [NUM_W-1:0] cfg_num = '0;
  logic [SRV_W-1:0] cfg_server = '0;
  logic [8:0]       cfg_prio = '0;
  logic             cfg_ack, cfg_err;
  logic             rej_valid = 1'b0;
  logic [NUM_W-1:0] rej_num = '0;
  logic             eoi_valid = 1'b0;
  logic [NUM_W-1:0] eoi_num = '0;
  logic             resend_req = 1'b0;
  logic             offer_valid;
  logic             offer_ready = 1'b1;
  logic [NUM_W-1:0] offer_num;
  logic [7:0]       offer_prio;
  logic [SRV_W-1:0] offer_server;

  int n_chk = 0;
  int n_fail = 0;
  int log_n = 0;
  int log_num [32];
  int log_prio[32];
  int log_srv [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  isc_source_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .line_i(line_i),
    .cfg_valid(cfg_valid), .cfg_op(cfg_op), .cfg_num(cfg_num),
    .cfg_server(cfg_server), .cfg_prio(cfg_prio),
    .cfg_ack(cfg_ack), .cfg_err(cfg_err),
    .rej_valid(rej_valid), .rej_num(rej_num),
    .eoi_valid(eoi_valid), .eoi_num(eoi_num),
    .resend_req(resend_req),
    .offer_valid(offer_valid), .offer_ready(offer_ready),
    .offer_num(offer_num), .offer_prio(offer_prio), .offer_server(offer_server)
  );

  // record accepted offers, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_n && offer_valid && offer_ready && log_n < 32) begin
      log_num[log_n]  = int'(offer_num);
      log_prio[log_n] = int'(offer_prio);
      log_srv[log_n]  = int'(offer_server);
      log_n++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic settle();
    repeat (N + 4) tick();
  endtask

  task automatic expect_count(input string tag, input int exp);
    chk(log_n == exp, tag, log_n, exp);
  endtask

  task automatic expect_entry(input string tag, input int k, input int num, input int prio,
                              input int srv);
    chk(log_num[k] == num,   {tag, " num"},    log_num[k],  num);
    chk(log_prio[k] == prio, {tag, " prio"},   log_prio[k], prio);
    if (srv >= 0) chk(log_srv[k] == srv, {tag, " server"}, log_srv[k], srv);
  endtask

  task automatic do_cfg(input int op, input int num, input int srv, input int prio,
                        input bit exp_err, input string tag);
    cfg_valid  = 1'b1;
    cfg_op     = 2'(op);
    cfg_num    = NUM_W'(num);
    cfg_server = SRV_W'(srv);
    cfg_prio   = 9'(prio);
    tick();
    cfg_valid = 1'b0;
    chk(cfg_ack == 1'b1, {tag, " ack"}, int'(cfg_ack), 1);
    chk(cfg_err == exp_err, {tag, " err"}, int'(cfg_err), int'(exp_err));
  endtask

  task automatic set_line(input int i, input bit v);
    line_i[i] = v;
    tick();
  endtask

  task automatic do_reject(input int num);
    rej_valid = 1'b1; rej_num = NUM_W'(num);
    tick();
    rej_valid = 1'b0;
  endtask

  task automatic do_eoi(input int num);
    eoi_valid = 1'b1; eoi_num = NUM_W'(num);
    tick();
    eoi_valid = 1'b0;
  endtask

  task automatic do_resend();
    resend_req = 1'b1;
    tick();
    resend_req = 1'b0;
    settle();
  endtask

  // R1, R4, R7
  task automatic t_reset_and_held();
    chk(offer_valid == 1'b0, "R1 offer_valid after reset", int'(offer_valid), 0);
    log_n = 0;
    set_line(0, 1'b1);
    settle();
    expect_count("R4 masked message not offered", 0);
    do_cfg(0, 16, 1, 5, 1'b0, "R7 route 16");
    settle();
    expect_count("R7 held message released", 1);
    expect_entry("R7 released offer", 0, 16, 5, 1);
  endtask

  // R3
  task automatic t_message();
    log_n = 0;
    do_cfg(0, 17, 2, 3, 1'b0, "R3 route 17");
    settle();
    expect_count("R3 no offer without edge", 0);
    set_line(1, 1'b1);
    settle();
    expect_count("R3 rising edge offers", 1);
    expect_entry("R3 offer", 0, 17, 3, 2);
    set_line(1, 1'b0);
    settle();
    expect_count("R3 falling edge ignored", 1);
  endtask

  // R2, R5, R6, R8 on a level source
  task automatic t_level();
    log_n = 0;
    do_cfg(0, 20, 0, 7, 1'b0, "R2 route 20");
    settle();
    expect_count("R2 not asserted no offer", 0);
    set_line(4, 1'b1);
    settle();
    expect_count("R2 assert offers", 1);
    expect_entry("R2 offer", 0, 20, 7, 0);
    do_resend();
    expect_count("R2 sent blocks resend", 1);
    do_reject(20);
    do_resend();
    expect_count("R5 R6 rejected level re-offered", 2);
    expect_entry("R6 level re-offer", 1, 20, 7, 0);
    do_eoi(20);
    do_resend();
    expect_count("R8 eoi lets level resend", 3);
    do_eoi(20);
    set_line(4, 1'b0);
    do_resend();
    expect_count("R2 deasserted no offer", 3);
  endtask

  // R5, R6, R8 on a message source
  task automatic t_message_reject();
    log_n = 0;
    do_reject(17);
    settle();
    expect_count("R5 reject alone no offer", 0);
    do_resend();
    expect_count("R6 rejected message re-offered", 1);
    expect_entry("R6 message re-offer", 0, 17, 3, 2);
    do_resend();
    expect_count("R6 rejected flag cleared", 1);
    do_eoi(17);
    do_resend();
    expect_count("R8 eoi on message no effect", 1);
  endtask

  // R9
  task automatic t_park();
    log_n = 0;
    do_cfg(0, 18, 3, 9, 1'b0, "R9 route 18");
    do_cfg(1, 18, 0, 0, 1'b0, "R9 disable 18");
    set_line(2, 1'b1);
    settle();
    expect_count("R9 disabled source silent", 0);
    do_cfg(2, 18, 0, 0, 1'b0, "R9 enable 18");
    settle();
    expect_count("R9 enable releases", 1);
    expect_entry("R9 restored priority", 0, 18, 9, 3);
  endtask

  // R10
  task automatic t_errors();
    log_n = 0;
    do_cfg(0, 15, 0, 1, 1'b1, "R10 number below base");
    do_cfg(0, 24, 0, 1, 1'b1, "R10 number above range");
    do_cfg(0, 19, 5, 1, 1'b1, "R10 server out of range");
    do_cfg(0, 19, 0, 256, 1'b1, "R10 priority above 0xFF");
    do_cfg(3, 19, 0, 1, 1'b1, "R10 op 3");
    set_line(3, 1'b1);
    settle();
    expect_count("R10 refused writes left source masked", 0);
    do_cfg(0, 19, 4, 2, 1'b0, "R10 valid route 19");
    settle();
    expect_count("R10 held survived refused writes", 1);
    expect_entry("R10 offer", 0, 19, 2, 4);
  endtask

  // R11
  task automatic t_backpressure();
    log_n = 0;
    set_line(1, 1'b0);
    set_line(2, 1'b0);
    offer_ready = 1'b0;
    line_i[2] = 1'b1;
    line_i[1] = 1'b1;
    tick();
    repeat (3) tick();
    chk(offer_valid == 1'b1, "R11 valid under back-pressure", int'(offer_valid), 1);
    chk(offer_num == 17, "R11 lowest number first", int'(offer_num), 17);
    repeat (3) tick();
    chk(offer_num == 17, "R11 offer held stable", int'(offer_num), 17);
    offer_ready = 1'b1;
    settle();
    expect_count("R11 both delivered", 2);
    expect_entry("R11 first", 0, 17, 3, 2);
    expect_entry("R11 second", 1, 18, 9, 3);
  endtask

  // R12
  task automatic t_reject_order();
    log_n = 0;
    set_line(1, 1'b0);
    set_line(2, 1'b0);
    offer_ready = 1'b0;
    line_i[1] = 1'b1;
    line_i[2] = 1'b1;
    tick();
    repeat (3) tick();
    offer_ready = 1'b1;
    rej_valid = 1'b1; rej_num = NUM_W'(18);
    tick();
    rej_valid = 1'b0;
    chk(offer_valid == 1'b0, "R12 rejected source not loaded", int'(offer_valid), 0);
    settle();
    expect_count("R12 offers after reject", 2);
    expect_entry("R12 held offer", 0, 17, 3, 2);
    expect_entry("R12 later offer", 1, 18, 9, 3);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset_and_held();
    t_message();
    t_level();
    t_message_reject();
    t_park();
    t_errors();
    t_backpressure();
    t_reject_order();
    finish_run();
  end
endmodule